// File: doc/BRIEF.md
# Byte-Command Acquisition Configuration Sequencer

This block is the control state machine of a two-channel sampling front end. A host sends it single bytes through a mailbox. A zero byte means "no command", so a command is any nonzero byte present on `cmd_byte` in a given clock cycle. The block always presents its current state code on `mbox_code`, and the host polls that code to track progress.

The block has four operating modes: idle, trigger armed, capture readout and scroll. From readout or scroll, the host enters a fixed-order chain of parameter-load states. Each of these states stores the next nonzero byte into one configuration register and then moves on. After the last state of the chain the block returns to idle.

The channel number is sent twice, once in each of two back-to-back states. It is committed only when both copies agree and name a valid channel. Otherwise the old channel is kept. The position, offset and gain trims are loaded into shadow registers. They reach the trim outputs only while the block sits in idle or scroll, so the trims stay frozen while a capture is armed. Trigger detection is external and arrives as a pulse on `trig_event`.

Top module: `acq_cmd_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after its release, `mbox_code` reads 0x00. On the next clock edge the block moves by itself to idle, which reads 0x01.
- R2: In idle, command 0x02 moves to armed (0x21), command 0x03 moves to readout (0x03), and command 0x04 moves to scroll (0x14). Each move takes effect at the clock edge that samples the command.
- R3: In armed, a `trig_event` pulse is remembered. Command 0x99 then moves to readout (0x03) if a trigger has been remembered, and leaves the block in armed if none has.
- R4: In armed, command 0xFE records an artificial trigger and leaves the block in armed, so the next 0x99 moves to readout. Command 0xFF moves straight to readout.
- R5: Command 0x04 in readout, or command 0xFF in scroll, enters the parameter chain at its first channel state, which reads 0x0F.
- R6: The chain opens with two states that both read 0x0F. `chan_sel` (reset value 1) takes the received value only if both bytes are equal and are 1 or 2. In every other case `chan_sel` keeps its old value, and the chain moves on regardless.
- R7: After the channel states, each nonzero byte is stored and the chain advances in this order: 0x05 rate, 0x08 second-subset step, 0x09 first-subset step, 0x06 coupling A, 0x07 coupling B, 0x0A shift, 0x0B edge, 0x0C position A, 0x0D position B, 0x0E trigger level, 0x10 offset A, 0x11 gain A, 0x12 offset B, 0x13 gain B. After 0x13 the block goes to idle (0x01). All configuration registers reset to 0.
- R8: The trim outputs `pos_trim`, `off_trim` and `gain_trim` are packed with channel A in bits 7:0 and channel B in bits 15:8, and reset to 0. They copy the loaded trims one cycle after any cycle spent in idle or scroll. In every other state they hold their value.
- R9: A zero byte never changes the state or any register. A nonzero byte that is not a valid command in idle, armed, readout or scroll is ignored.
- R10: A trigger remembered in armed is forgotten once the block leaves armed. A `trig_event` pulse that arrives outside armed is never remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_byte | input | 8 | Mailbox byte from the host; zero means no command |
| trig_event | input | 1 | Trigger detector pulse |
| mbox_code | output | 8 | Current state code posted to the mailbox |
| chan_sel | output | 2 | Committed channel number (1 or 2) |
| rate_idx | output | 8 | Sample rate index |
| step_second | output | 8 | Second-subset step plus one |
| step_first | output | 8 | First-subset step plus one |
| couple_a | output | 8 | Coupling/range and trigger source byte A |
| couple_b | output | 8 | Coupling/range and trigger type byte B |
| shift_sel | output | 8 | Subset offset parameter plus one |
| edge_sel | output | 8 | Trigger edge selection byte |
| trig_level | output | 8 | Trigger level |
| pos_trim | output | 16 | Live position trims {B, A} |
| off_trim | output | 16 | Live offset trims {B, A} |
| gain_trim | output | 16 | Live gain trims {B, A} |

## Verification
The assertions check the following on every cycle:
- the automatic move out of the transient state;
- a zero byte leaves the state unchanged;
- 0xFE keeps the block armed with a trigger pending;
- an unanswered query stays armed;
- `chan_sel` is always legal;
- the live trims stay frozen outside idle and scroll.

The bench scenarios cover what a single-cycle property cannot:
- the full order of the chain and which register each byte lands in;
- the mismatched and out-of-range channel pairs;
- a trigger that arrives before arming being ignored;
- trims loaded in the chain appearing only after the block returns to idle.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;

    localparam int BYTE_W = 8;
    localparam int NCH    = 2;

    typedef logic [BYTE_W-1:0] byte_t;

    // Internal states; the chain states are contiguous and in load order.
    typedef enum logic [4:0] {
        ST_INIT, ST_IDLE, ST_ARMED, ST_READ, ST_SCROLL,
        ST_CH1, ST_CH2, ST_RATE, ST_STEP2, ST_STEP1,
        ST_CPLA, ST_CPLB, ST_SHIFT, ST_EDGE, ST_POSA,
        ST_POSB, ST_TLVL, ST_OFFA, ST_GAINA, ST_OFFB, ST_GAINB
    } seq_st_e;

    localparam byte_t CMD_ARM    = 8'h02;
    localparam byte_t CMD_READ   = 8'h03;
    localparam byte_t CMD_CFG    = 8'h04;
    localparam byte_t CMD_POLL   = 8'h99;
    localparam byte_t CMD_FORCE  = 8'hFE;
    localparam byte_t CMD_ABORT  = 8'hFF;

    typedef struct packed {
        byte_t gain;
        byte_t off;
        byte_t pos;
    } trim_t;

    function automatic byte_t state_code(seq_st_e s);
        case (s)
            ST_INIT:   return 8'h00;
            ST_IDLE:   return 8'h01;
            ST_ARMED:  return 8'h21;
            ST_READ:   return 8'h03;
            ST_SCROLL: return 8'h14;
            ST_CH1,
            ST_CH2:    return 8'h0F;
            ST_RATE:   return 8'h05;
            ST_STEP2:  return 8'h08;
            ST_STEP1:  return 8'h09;
            ST_CPLA:   return 8'h06;
            ST_CPLB:   return 8'h07;
            ST_SHIFT:  return 8'h0A;
            ST_EDGE:   return 8'h0B;
            ST_POSA:   return 8'h0C;
            ST_POSB:   return 8'h0D;
            ST_TLVL:   return 8'h0E;
            ST_OFFA:   return 8'h10;
            ST_GAINA:  return 8'h11;
            ST_OFFB:   return 8'h12;
            default:   return 8'h13;
        endcase
    endfunction

    function automatic seq_st_e chain_next(seq_st_e s);
        if (s == ST_GAINB) return ST_IDLE;
        return seq_st_e'(s + 5'd1);
    endfunction

endpackage

// File: rtl/acq_seq_fsm.sv
module acq_seq_fsm
    import acq_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  byte_t   cmd,
    input  logic    trig_event,
    output seq_st_e st_q,
    output logic    pend_q
);
    seq_st_e st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_INIT:   st_d = ST_IDLE;
            ST_IDLE: begin
                if (cmd == CMD_ARM)       st_d = ST_ARMED;
                else if (cmd == CMD_READ) st_d = ST_READ;
                else if (cmd == CMD_CFG)  st_d = ST_SCROLL;
            end
            ST_ARMED: begin
                if (cmd == CMD_POLL && pend_q) st_d = ST_READ;
                else if (cmd == CMD_ABORT)     st_d = ST_READ;
            end
            ST_READ:   if (cmd == CMD_CFG)   st_d = ST_CH1;
            ST_SCROLL: if (cmd == CMD_ABORT) st_d = ST_CH1;
            default:   if (cmd != '0)        st_d = chain_next(st_q);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_INIT;
            pend_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q != ST_ARMED)
                pend_q <= 1'b0;
            else if (trig_event || cmd == CMD_FORCE)
                pend_q <= 1'b1;
        end
    end

    a_r1_init_to_idle: assert property (@(posedge clk) disable iff (rst)
        st_q == ST_INIT |=> st_q == ST_IDLE);
    a_r9_zero_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd == '0 && st_q != ST_INIT) |=> $stable(st_q));
    a_r4_force_stays: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ARMED && cmd == CMD_FORCE) |=> (st_q == ST_ARMED && pend_q));
    a_r3_query_waits: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ARMED && cmd == CMD_POLL && !pend_q) |=> st_q == ST_ARMED);
    a_r10_pend_only_armed: assert property (@(posedge clk) disable iff (rst)
        st_q != ST_ARMED |=> !pend_q);
endmodule

// File: rtl/acq_seq_regs.sv
module acq_seq_regs
    import acq_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_st_e          st_q,
    input  byte_t            cmd,
    output logic [1:0]       chan_q,
    output byte_t            rate_q,
    output byte_t            step2_q,
    output byte_t            step1_q,
    output byte_t            cpla_q,
    output byte_t            cplb_q,
    output byte_t            shift_q,
    output byte_t            edge_q,
    output byte_t            tlvl_q,
    output trim_t [NCH-1:0]  shadow_q
);
    byte_t ch_first_q;
    logic  ch_ok;

    assign ch_ok = (cmd == ch_first_q) && (cmd == 8'd1 || cmd == 8'd2);

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_q     <= 2'd1;
            ch_first_q <= '0;
            rate_q     <= '0;
            step2_q    <= '0;
            step1_q    <= '0;
            cpla_q     <= '0;
            cplb_q     <= '0;
            shift_q    <= '0;
            edge_q     <= '0;
            tlvl_q     <= '0;
            shadow_q   <= '0;
        end else if (cmd != '0) begin
            case (st_q)
                ST_CH1:   ch_first_q <= cmd;
                ST_CH2:   if (ch_ok) chan_q <= cmd[1:0];
                ST_RATE:  rate_q  <= cmd;
                ST_STEP2: step2_q <= cmd;
                ST_STEP1: step1_q <= cmd;
                ST_CPLA:  cpla_q  <= cmd;
                ST_CPLB:  cplb_q  <= cmd;
                ST_SHIFT: shift_q <= cmd;
                ST_EDGE:  edge_q  <= cmd;
                ST_POSA:  shadow_q[0].pos  <= cmd;
                ST_POSB:  shadow_q[1].pos  <= cmd;
                ST_TLVL:  tlvl_q  <= cmd;
                ST_OFFA:  shadow_q[0].off  <= cmd;
                ST_GAINA: shadow_q[0].gain <= cmd;
                ST_OFFB:  shadow_q[1].off  <= cmd;
                ST_GAINB: shadow_q[1].gain <= cmd;
                default: ;
            endcase
        end
    end

    a_r6_chan_legal: assert property (@(posedge clk) disable iff (rst)
        (chan_q == 2'd1 || chan_q == 2'd2));
    a_r9_zero_no_load: assert property (@(posedge clk) disable iff (rst)
        cmd == '0 |=> ($stable(rate_q) && $stable(tlvl_q) && $stable(shadow_q)));
endmodule

// File: rtl/acq_seq_cal.sv
module acq_seq_cal
    import acq_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  seq_st_e          st_q,
    input  trim_t [NCH-1:0]  shadow_q,
    output trim_t [NCH-1:0]  live_q
);
    logic refresh;

    assign refresh = (st_q == ST_IDLE) || (st_q == ST_SCROLL);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)          live_q[g] <= '0;
            else if (refresh) live_q[g] <= shadow_q[g];
        end
    end

    a_r8_frozen: assert property (@(posedge clk) disable iff (rst)
        !refresh |=> $stable(live_q));
endmodule

// File: rtl/acq_cmd_seq.sv
module acq_cmd_seq
    import acq_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  cmd_byte,
    input  logic        trig_event,
    output logic [7:0]  mbox_code,
    output logic [1:0]  chan_sel,
    output logic [7:0]  rate_idx,
    output logic [7:0]  step_second,
    output logic [7:0]  step_first,
    output logic [7:0]  couple_a,
    output logic [7:0]  couple_b,
    output logic [7:0]  shift_sel,
    output logic [7:0]  edge_sel,
    output logic [7:0]  trig_level,
    output logic [15:0] pos_trim,
    output logic [15:0] off_trim,
    output logic [15:0] gain_trim
);
    seq_st_e         st_q;
    logic            pend_q;
    trim_t [NCH-1:0] shadow_q;
    trim_t [NCH-1:0] live_q;

    acq_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .cmd(cmd_byte), .trig_event(trig_event),
        .st_q(st_q), .pend_q(pend_q)
    );

    acq_seq_regs u_regs (
        .clk(clk), .rst(rst), .st_q(st_q), .cmd(cmd_byte),
        .chan_q(chan_sel), .rate_q(rate_idx), .step2_q(step_second),
        .step1_q(step_first), .cpla_q(couple_a), .cplb_q(couple_b),
        .shift_q(shift_sel), .edge_q(edge_sel), .tlvl_q(trig_level),
        .shadow_q(shadow_q)
    );

    acq_seq_cal u_cal (
        .clk(clk), .rst(rst), .st_q(st_q), .shadow_q(shadow_q), .live_q(live_q)
    );

    assign mbox_code = state_code(st_q);

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign pos_trim [g*BYTE_W +: BYTE_W] = live_q[g].pos;
        assign off_trim [g*BYTE_W +: BYTE_W] = live_q[g].off;
        assign gain_trim[g*BYTE_W +: BYTE_W] = live_q[g].gain;
    end
endmodule

// File: tb/acq_cmd_seq_bench.sv
module acq_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cmd_byte = 8'h00;
    logic        trig_event = 1'b0;
    logic [7:0]  mbox_code, rate_idx, step_second, step_first, couple_a, couple_b;
    logic [7:0]  shift_sel, edge_sel, trig_level;
    logic [1:0]  chan_sel;
    logic [15:0] pos_trim, off_trim, gain_trim;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    acq_cmd_seq u_acq_cmd_seq (
        .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .trig_event(trig_event),
        .mbox_code(mbox_code), .chan_sel(chan_sel), .rate_idx(rate_idx),
        .step_second(step_second), .step_first(step_first),
        .couple_a(couple_a), .couple_b(couple_b), .shift_sel(shift_sel),
        .edge_sel(edge_sel), .trig_level(trig_level),
        .pos_trim(pos_trim), .off_trim(off_trim), .gain_trim(gain_trim)
    );

    // Behavioural reference: mode 0 init, 1 idle, 2 armed, 3 readout,
    // 4 scroll, 100+k chain slot k.
    int m_mode = 0;
    int m_flag = 0;
    int m_first = 0;
    int m_chan = 1;
    int par [16];
    int live [6];
    int slot_code [16] = '{'h0F, 'h0F, 'h05, 'h08, 'h09, 'h06, 'h07, 'h0A,
                           'h0B, 'h0C, 'h0D, 'h0E, 'h10, 'h11, 'h12, 'h13};
    int trim_slot [6] = '{9, 12, 13, 10, 14, 15}; // posA offA gainA posB offB gainB

    function automatic int mode_code(int m);
        case (m)
            0: return 'h00;
            1: return 'h01;
            2: return 'h21;
            3: return 'h03;
            4: return 'h14;
            default: return slot_code[m-100];
        endcase
    endfunction

    always @(posedge clk) begin
        int c;
        int nm;
        c = cmd_byte;
        if (rst) begin
            m_mode = 0; m_flag = 0; m_first = 0; m_chan = 1;
            foreach (par[i]) par[i] = 0;
            foreach (live[i]) live[i] = 0;
        end else begin
            if (m_mode == 1 || m_mode == 4)
                foreach (live[i]) live[i] = par[trim_slot[i]];
            nm = m_mode;
            case (m_mode)
                0: nm = 1;
                1: if (c == 2) nm = 2; else if (c == 3) nm = 3; else if (c == 4) nm = 4;
                2: if ((c == 'h99 && m_flag != 0) || c == 'hFF) nm = 3;
                3: if (c == 4) nm = 100;
                4: if (c == 'hFF) nm = 100;
                default: if (c != 0) begin
                    int k;
                    k = m_mode - 100;
                    par[k] = c;
                    if (k == 0) m_first = c;
                    if (k == 1 && c == m_first && (c == 1 || c == 2)) m_chan = c;
                    nm = (k == 15) ? 1 : m_mode + 1;
                end
            endcase
            if (m_mode != 2) m_flag = 0;
            else if (trig_event || c == 'hFE) m_flag = 1;
            m_mode = nm;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            chk("R1/R2/R3/R4/R5/R9/R10 mbox_code", mbox_code, mode_code(m_mode));
            chk("R6 chan_sel", chan_sel, m_chan);
            chk("R7 rate_idx", rate_idx, par[2]);
            chk("R7 step_second", step_second, par[3]);
            chk("R7 step_first", step_first, par[4]);
            chk("R7 couple_a", couple_a, par[5]);
            chk("R7 couple_b", couple_b, par[6]);
            chk("R7 shift_sel", shift_sel, par[7]);
            chk("R7 edge_sel", edge_sel, par[8]);
            chk("R7 trig_level", trig_level, par[11]);
            chk("R8 pos_trim", pos_trim, (live[3] << 8) | live[0]);
            chk("R8 off_trim", off_trim, (live[4] << 8) | live[1]);
            chk("R8 gain_trim", gain_trim, (live[5] << 8) | live[2]);
        end
    end

    task automatic put(int b, bit t = 1'b0);
        @(negedge clk);
        #2;
        cmd_byte = 8'(b);
        trig_event = t;
    endtask

    task automatic chain(int base, int ch1, int ch2);
        put(ch1);
        put(0);
        put(ch2);
        for (int i = 2; i < 16; i++) put(base + i);
        put(0);
        put(0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset code", mbox_code, 'h00);
        @(negedge clk);
        #2 rst = 1'b0;
        put(0); put(0);
        // R9: junk and zero bytes in idle are ignored
        put('h55); put('hFE); put(0);
        // R10: trigger pulse in idle is not remembered
        put(0, 1'b1); put(0);
        put('h02);             // R2 arm
        put('h99); put(0);     // R3 no trigger: stays armed
        put(0, 1'b1); put(0);  // R3 trigger pulse
        put('h99); put(0);     // R3 -> readout
        put('h04); put(0);     // R5 -> chain
        chain('h20, 2, 2);     // R6 commit 2, R7 order, R8 refresh in idle
        put('h02); put('hFE); put(0); put('h99); put(0); // R4 forced trigger
        put('h04);
        chain('h40, 1, 2);     // R6 mismatch dropped
        put('h04); put(0);     // R2 scroll
        put('h33); put('hFF);  // R5 scroll -> chain
        chain('h60, 3, 3);     // R6 out-of-range dropped
        put('h03); put(0);     // R2 direct readout
        put('h04);
        chain('h80, 1, 1);     // R6 commit 1
        put('h02); put(0, 1'b1); put('hFF); put(0); // R4 abort, R10 flag cleared
        put('h04); put(0); put('h05); put(0);
        put(0); put(0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule